// File: doc/BRIEF.md
# Multi-mode sample demultiplexer

This block is the digital back end of a pipelined 8-bit sampling converter. On every rising edge of the fast sample clock it takes one converted code. It then hands the codes to two output ports, A and B, after a fixed pipeline delay. Each port has a companion clock output that a slower receiver uses to capture it.

A two-bit mode input selects how codes are spread over the ports:
- **Straight:** every code goes to port A at the full rate.
- **In-phase:** codes alternate between A and B, and B is held back one extra clock so that both ports change on the same edge.
- **Staggered:** codes alternate between A and B with equal delay, so the two ports change on alternate edges.
- **Parked:** all outputs are held at zero.

A synchronous phase-reset input fixes which code goes to which port. A power-down input clears the pipeline, and a per-port ready flag reports when the pipeline has refilled. A high-impedance request is passed out as drive enables.

Top module: `adc_demux_top`

## Requirements
- R1: `mode_sel` is decoded as 2'b11 straight, 2'b10 in-phase, 2'b01 staggered and 2'b00 parked. In parked mode both data ports and both port clocks are zero, and both ready flags are low.
- R2: In straight mode, the code captured at rising edge k appears on `port_a` after edge k+5. `port_b` and `pclk_b` stay zero, and `pclk_a` is held high.
- R3: In in-phase mode, a code tagged for A appears on `port_a` after edge k+5 and a code tagged for B appears on `port_b` after edge k+6. Each port holds its value between updates.
- R4: In staggered mode, a code captured at edge k appears on its port after edge k+5. A codes and B codes therefore update on alternate edges.
- R5: In both alternating modes, a port clock is high for the one cycle that follows an edge at which that port loaded a code, and low otherwise. The port data does not change while its clock is low.
- R6: Each code is tagged with the divider phase present at its capture edge: phase 0 goes to A and phase 1 goes to B. The phase toggles every edge. An edge with `phase_rst` high forces the next phase to 0, so the first code captured after release goes to A.
- R7: `drv_a` and `drv_b` are the inverse of `hiz_req`, and `hiz_req` has no effect on the data or the port clocks.
- R8: An edge with `pwr_dn` high clears the pipeline, both ports, both port clocks, the divider phase and the ready count.
- R9: Once `pwr_dn` is low, the ready count reaches five on the fifth edge. `vld_a` is then high in every mode except parked, and `vld_b` is high only in the two alternating modes.
- R10: While `rst_n` is low, all data, port clock and ready outputs are zero. Reset release is synchronised with two flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_i | input | 8 | Converted code, one per rising edge |
| mode_sel | input | 2 | Distribution mode (see R1) |
| phase_rst | input | 1 | Synchronous divider phase reset |
| hiz_req | input | 1 | Request to release the output drivers |
| pwr_dn | input | 1 | Power-down, clears the pipeline |
| port_a | output | 8 | Port A data |
| port_b | output | 8 | Port B data |
| pclk_a | output | 1 | Port A companion clock |
| pclk_b | output | 1 | Port B companion clock |
| drv_a | output | 1 | Port A driver enable |
| drv_b | output | 1 | Port B driver enable |
| vld_a | output | 1 | Port A pipeline refilled |
| vld_b | output | 1 | Port B pipeline refilled |

## Verification
Each mode is fed a strided ramp of codes straight after a power-down. This makes every code unique, so an off-by-one latency, a swapped port or a lost hold appears as a wrong value rather than a coincidental match. The in-phase and staggered runs differ only in port B's delay, which separates R3 from R4. Runs with `phase_rst` pulses, including a two-edge pulse, push several consecutive codes to port A and show that the phase tags follow the reset rather than a free-running count. Toggling `hiz_req` during the ramps shows that the drive enables move while the data stream stays undisturbed.

// File: rtl/adc_demux_pkg.sv
`timescale 1ns/1ps
package adc_demux_pkg;

  // encoding is the mode_sel input value
  typedef enum logic [1:0] {
    MODE_PARK = 2'b00,
    MODE_STAG = 2'b01,
    MODE_INPH = 2'b10,
    MODE_STRT = 2'b11
  } mode_e;

  function automatic logic is_split(input mode_e m);
    return (m == MODE_STAG) || (m == MODE_INPH);
  endfunction

endpackage

// File: rtl/adc_phase_div.sv
`timescale 1ns/1ps
module adc_phase_div (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_dn,
  input  logic phase_rst,
  output logic phase
);

  logic ph_q;
  logic ph_d;

  always_comb begin
    if (pwr_dn || phase_rst) ph_d = 1'b0;
    else                     ph_d = ~ph_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= 1'b0;
    else        ph_q <= ph_d;
  end

  assign phase = ph_q;

  // R6: a phase reset leaves phase 0 for the next capture
  p_rst_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    phase_rst |=> !phase);

  // R6: free-running alternation
  p_alternate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!phase_rst && !pwr_dn) |=> (phase != $past(phase)));

endmodule

// File: rtl/adc_sample_pipe.sv
`timescale 1ns/1ps
module adc_sample_pipe #(
  parameter int W     = 8,
  parameter int DEPTH = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pwr_dn,
  input  logic [W-1:0] samp_i,
  input  logic         tag_i,
  output logic [W+1:0] tap_lo,
  output logic [W+1:0] tap_hi
);

  // entry layout: [W+1] occupied, [W] port tag, [W-1:0] code
  localparam int EW = W + 2;

  logic [EW-1:0] stg_q [DEPTH];
  logic [EW-1:0] stg_d [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    if (s == 0) begin : g_head
      always_comb begin
        if (pwr_dn) stg_d[s] = '0;
        else        stg_d[s] = {1'b1, tag_i, samp_i};
      end
    end else begin : g_body
      always_comb begin
        if (pwr_dn) stg_d[s] = '0;
        else        stg_d[s] = stg_q[s-1];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else        stg_q[s] <= stg_d[s];
    end
  end

  assign tap_lo = stg_q[DEPTH-2];
  assign tap_hi = stg_q[DEPTH-1];

  // R8: power-down empties the delay line
  p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> (tap_lo == '0 && tap_hi == '0));

endmodule

// File: rtl/adc_port_stage.sv
`timescale 1ns/1ps
module adc_port_stage
  import adc_demux_pkg::*;
#(
  parameter int W    = 8,
  parameter bit IS_B = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pwr_dn,
  input  mode_e        mode,
  input  logic [W+1:0] tap_lo,
  input  logic [W+1:0] tap_hi,
  output logic [W-1:0] dat_o,
  output logic         pclk_o
);

  logic [W+1:0] src;
  logic         silent;
  logic         take;
  logic [W-1:0] dat_q;
  logic [W-1:0] dat_d;
  logic         clk_q;
  logic         clk_d;

  always_comb begin
    src    = (IS_B && mode == MODE_INPH) ? tap_hi : tap_lo;
    silent = pwr_dn || (mode == MODE_PARK) || (IS_B && mode == MODE_STRT);
    if (mode == MODE_STRT) take = src[W+1];
    else                   take = src[W+1] && (src[W] == IS_B);
    if (silent) begin
      dat_d = '0;
      clk_d = 1'b0;
    end else begin
      dat_d = take ? src[W-1:0] : dat_q;
      clk_d = (mode == MODE_STRT) ? 1'b1 : take;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '0;
      clk_q <= 1'b0;
    end else begin
      dat_q <= dat_d;
      clk_q <= clk_d;
    end
  end

  assign dat_o  = dat_q;
  assign pclk_o = clk_q;

  // R8: nothing leaves the port after a power-down edge
  p_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pwr_dn) |-> (dat_o == '0 && !pclk_o));

  // R1: parked mode holds the port at zero
  p_park_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == MODE_PARK) |-> (dat_o == '0 && !pclk_o));

  // R5: in alternating modes data only moves together with its clock
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_split(mode) && $past(mode) == mode && !$past(pwr_dn) && !pclk_o)
      |-> $stable(dat_o));

endmodule

// File: rtl/adc_wake_cnt.sv
`timescale 1ns/1ps
module adc_wake_cnt #(
  parameter int WAKE = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_dn,
  output logic ready
);

  localparam int CW = $clog2(WAKE + 1);
  localparam logic [CW-1:0] WAKE_C = CW'(WAKE);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = pwr_dn || (cnt_q != WAKE_C);
    if (pwr_dn) cnt_d = '0;
    else        cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign ready = (cnt_q == WAKE_C);

  // R9: the count saturates
  p_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= WAKE_C);

  // R9: power-down always drops readiness
  p_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> !ready);

endmodule

// File: rtl/adc_demux_top.sv
`timescale 1ns/1ps
module adc_demux_top
  import adc_demux_pkg::*;
#(
  parameter int W    = 8,
  parameter int LAT  = 5,
  parameter int WAKE = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] samp_i,
  input  logic [1:0]   mode_sel,
  input  logic         phase_rst,
  input  logic         hiz_req,
  input  logic         pwr_dn,
  output logic [W-1:0] port_a,
  output logic [W-1:0] port_b,
  output logic         pclk_a,
  output logic         pclk_b,
  output logic         drv_a,
  output logic         drv_b,
  output logic         vld_a,
  output logic         vld_b
);

  localparam int DEPTH = LAT + 1;

  logic         rst_meta;
  logic         rst_n_s;
  mode_e        mode;
  logic         phase;
  logic         ready;
  logic [W+1:0] tap_lo;
  logic [W+1:0] tap_hi;
  logic [W-1:0] pdat [2];
  logic         pck  [2];

  // reset: asserted at once, released on the second edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  assign mode = mode_e'(mode_sel);

  adc_phase_div u_div (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .pwr_dn    (pwr_dn),
    .phase_rst (phase_rst),
    .phase     (phase)
  );

  adc_sample_pipe #(.W(W), .DEPTH(DEPTH)) u_pipe (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .pwr_dn (pwr_dn),
    .samp_i (samp_i),
    .tag_i  (phase),
    .tap_lo (tap_lo),
    .tap_hi (tap_hi)
  );

  for (genvar p = 0; p < 2; p++) begin : g_port
    adc_port_stage #(.W(W), .IS_B(p == 1)) u_port (
      .clk    (clk),
      .rst_n  (rst_n_s),
      .pwr_dn (pwr_dn),
      .mode   (mode),
      .tap_lo (tap_lo),
      .tap_hi (tap_hi),
      .dat_o  (pdat[p]),
      .pclk_o (pck[p])
    );
  end

  adc_wake_cnt #(.WAKE(WAKE)) u_wake (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .pwr_dn (pwr_dn),
    .ready  (ready)
  );

  assign port_a = pdat[0];
  assign port_b = pdat[1];
  assign pclk_a = pck[0];
  assign pclk_b = pck[1];
  assign drv_a  = ~hiz_req;
  assign drv_b  = ~hiz_req;
  assign vld_a  = ready && (mode != MODE_PARK);
  assign vld_b  = ready && is_split(mode);

  // R2: port B is quiet in straight mode
  p_b_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mode == MODE_STRT && $past(mode) == MODE_STRT) |-> (port_b == '0 && !pclk_b));

  // R10: reset clears the visible outputs
  p_reset_r10: assert property (@(posedge clk)
    !rst_n |-> (port_a == '0 && port_b == '0 && !pclk_a && !pclk_b && !vld_a && !vld_b));

endmodule

// File: tb/sim_adc_demux_top.sv
`timescale 1ns/1ps
module sim_adc_demux_top;

  logic       clk;
  logic       rst_n;
  logic [7:0] samp_i;
  logic [1:0] mode_sel;
  logic       phase_rst;
  logic       hiz_req;
  logic       pwr_dn;
  logic [7:0] port_a;
  logic [7:0] port_b;
  logic       pclk_a;
  logic       pclk_b;
  logic       drv_a;
  logic       drv_b;
  logic       vld_a;
  logic       vld_b;

  int n_vec;
  int n_bad;
  bit fin;

  logic [7:0] hv [0:79];
  logic       ht [0:79];

  adc_demux_top u0 (
    .clk(clk), .rst_n(rst_n), .samp_i(samp_i), .mode_sel(mode_sel),
    .phase_rst(phase_rst), .hiz_req(hiz_req), .pwr_dn(pwr_dn),
    .port_a(port_a), .port_b(port_b), .pclk_a(pclk_a), .pclk_b(pclk_b),
    .drv_a(drv_a), .drv_b(drv_b), .vld_a(vld_a), .vld_b(vld_b)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [8:0] act, input logic [8:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // latest code of matching tag captured no later than j-lat
  task automatic model(input int j, input int lat, input bit any, input bit want,
                       output logic [7:0] val, output logic hit);
    val = 8'h00;
    hit = 1'b0;
    for (int i = 0; i <= j - lat; i++) begin
      if (any || ht[i] == want) val = hv[i];
    end
    if (j - lat >= 0) hit = any || (ht[j-lat] == want);
  endtask

  task automatic all_quiet(input string req);
    chk(req, "port_a", {1'b0, port_a}, 9'h0);
    chk(req, "port_b", {1'b0, port_b}, 9'h0);
    chk(req, "pclk_a", {8'h0, pclk_a}, 9'h0);
    chk(req, "pclk_b", {8'h0, pclk_b}, 9'h0);
    chk(req, "vld_a",  {8'h0, vld_a},  9'h0);
    chk(req, "vld_b",  {8'h0, vld_b},  9'h0);
  endtask

  task automatic run(input logic [1:0] ms, input int n, input int base, input bit use_rst);
    int   ph;
    logic [7:0] ea;
    logic [7:0] eb;
    logic ha;
    logic hb;
    string rq;
    mode_sel  = ms;
    pwr_dn    = 1'b1;
    phase_rst = 1'b0;
    hiz_req   = 1'b0;
    repeat (3) @(negedge clk);
    all_quiet("R8");
    ph = 0;
    for (int j = 0; j < n; j++) begin
      logic rr;
      logic hz;
      rr = use_rst && (j == 10 || j == 11 || j == 20);
      hz = (j % 7 == 3);
      pwr_dn    = 1'b0;
      phase_rst = rr;
      hiz_req   = hz;
      samp_i    = 8'(base + j * 3);
      hv[j]     = samp_i;
      ht[j]     = ph[0];
      ph        = rr ? 0 : 1 - ph;
      @(negedge clk);
      case (ms)
        2'b11: rq = "R2";
        2'b10: rq = "R3";
        2'b01: rq = "R4";
        default: rq = "R1";
      endcase
      if (use_rst) rq = "R6";
      if (ms == 2'b11) begin
        model(j, 5, 1'b1, 1'b0, ea, ha);
        chk(rq, "port_a", {1'b0, port_a}, {1'b0, ea});
        chk("R2", "port_b", {1'b0, port_b}, 9'h0);
        chk("R2", "pclk_a", {8'h0, pclk_a}, 9'h1);
        chk("R2", "pclk_b", {8'h0, pclk_b}, 9'h0);
      end else if (ms == 2'b00) begin
        chk("R1", "port_a", {1'b0, port_a}, 9'h0);
        chk("R1", "port_b", {1'b0, port_b}, 9'h0);
        chk("R1", "pclk_a", {8'h0, pclk_a}, 9'h0);
        chk("R1", "pclk_b", {8'h0, pclk_b}, 9'h0);
      end else begin
        model(j, 5, 1'b0, 1'b0, ea, ha);
        model(j, (ms == 2'b10) ? 6 : 5, 1'b0, 1'b1, eb, hb);
        chk(rq, "port_a", {1'b0, port_a}, {1'b0, ea});
        chk(rq, "port_b", {1'b0, port_b}, {1'b0, eb});
        chk("R5", "pclk_a", {8'h0, pclk_a}, {8'h0, ha});
        chk("R5", "pclk_b", {8'h0, pclk_b}, {8'h0, hb});
      end
      chk("R9", "vld_a", {8'h0, vld_a}, {8'h0, (j >= 4) && (ms != 2'b00)});
      chk("R9", "vld_b", {8'h0, vld_b}, {8'h0, (j >= 4) && (ms == 2'b01 || ms == 2'b10)});
      chk("R7", "drv_a", {8'h0, drv_a}, {8'h0, ~hz});
      chk("R7", "drv_b", {8'h0, drv_b}, {8'h0, ~hz});
    end
  endtask

  initial begin
    n_vec = 0;
    n_bad = 0;
    fin   = 1'b0;
    rst_n = 1'b0;
    samp_i = 8'h5A;
    mode_sel = 2'b11;
    phase_rst = 1'b0;
    hiz_req = 1'b0;
    pwr_dn = 1'b0;
    repeat (3) @(negedge clk);
    all_quiet("R10");
    rst_n = 1'b1;
    run(2'b11, 30, 8'h10, 1'b0);
    run(2'b10, 40, 8'h40, 1'b0);
    run(2'b01, 40, 8'h80, 1'b0);
    run(2'b01, 40, 8'hA0, 1'b1);
    run(2'b10, 40, 8'hC0, 1'b1);
    run(2'b00, 12, 8'h20, 1'b0);
    run(2'b11, 12, 8'h30, 1'b0);
    fin = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!fin) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule